// File: doc/BRIEF.md
# Edge-Latched Static Memory Core

This block is a small static memory whose bus behaviour follows an early CMOS RAM that is paced by an enable strobe. Driving the strobe low opens an access cycle and freezes the address in an internal register. Two active-low selects gate the data output, and an active-low write strobe chooses between reading and writing. Data in and data out use separate pins. Driving the strobe high closes the cycle. On that edge, the word being presented is caught in an output register, so read data stays available after the cycle has ended.

The block is fully synchronous. A fast system clock samples the strobe, the selects and the write strobe on every rising edge, and edges are found by comparing each sample with the one before. A real tri-state pad is represented by two outputs: an output-enable flag, and a data value that reads zero whenever the enable is low. The strobe, selects, write strobe, address and data inputs are assumed to be synchronous to the clock. After reset, and before any read, the word being read must have been written.

Top module: `edge_latched_sram`

## Requirements
- R1: The address is loaded on the clock edge that first samples `strb_n` low after it was high. Address changes later in the same cycle do not change the word that is read or written.
- R2: The output is enabled only while `sel_a_n` and `sel_b_n` are both low. If either select is high, `q_oe` is 0 and `q` is 0 in that same cycle, whatever the state of the strobe.
- R3: One clock after the strobe's falling edge, with both selects low and `we_n` high, `q_oe` is 1 and `q` shows the stored word at the latched address.
- R4: On the clock edge that first samples `strb_n` high, the presented word is caught in an output register. While the selects stay low and `we_n` stays high, `q_oe` remains 1 and `q` keeps that word after the cycle has ended.
- R5: While the output register is holding a word, taking both selects low again after a deselect enables the output again with the same held word.
- R6: The next falling edge of the strobe releases the held word. One clock later, `q` shows the word at the newly latched address.
- R7: A write needs `strb_n`, `sel_a_n`, `sel_b_n` and `we_n` all sampled low in the same clock. The word is stored at the latched address on the first clock that samples either `we_n` or `strb_n` back high, using the `d` value sampled on that clock.
- R8: While `we_n` is low, `q_oe` is 0 and `q` is 0.
- R9: After reset, with the strobe and selects high, `q_oe` is 0 and `q` is 0.
- R10: A strobe cycle in which a select is high while `we_n` is low stores nothing. Each armed write commits exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all controls |
| rst_n | input | 1 | Synchronous active-low reset |
| strb_n | input | 1 | Active-low cycle strobe; its falling edge latches the address |
| sel_a_n | input | 1 | First active-low select |
| sel_b_n | input | 1 | Second active-low select |
| we_n | input | 1 | Active-low write strobe |
| addr | input | 10 | Word address |
| d | input | 1 | Write data |
| q | output | 1 | Read data; 0 while the output is disabled |
| q_oe | output | 1 | Output enable, standing in for tri-state drive |

## Verification
The embedded assertions check these on every clock:
- the latched address stays still between strobe falling edges;
- a strobe rise sets the hold flag and a strobe fall clears it;
- a write commit never lasts two clocks in a row;
- the output is never enabled during a write.

Some behaviour depends on what was stored earlier, so only the directed scenarios can show it:
- that the right word appears after an address change in mid-cycle;
- that a held word survives a deselect and reappears;
- that a write finishes on whichever of the two strobes rises first;
- that a deselected write leaves the array unchanged.

// File: rtl/els_pkg.sv
// Package: shared parameters and types for the edge-latched memory.
// Assumes: one-bit words by default; the depth is a power of two.
package els_pkg;
    localparam int unsigned DEF_DEPTH = 1024;
    localparam int unsigned DEF_DW    = 1;

    // Edge events seen on the sampled strobes during one clock.
    typedef struct packed {
        logic strb_fall;
        logic strb_rise;
        logic we_rise;
    } strobe_ev_t;
endpackage

// File: rtl/els_strobe_edges.sv
// Module: detects edges on the cycle strobe and the write strobe by keeping
// last clock's sample of each. Assumes the inputs are synchronous to clk.
// Both samples reset to high (idle), so a strobe held low through reset is
// seen as a falling edge on the first clock after reset.
module els_strobe_edges
    import els_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strb_n,
    input  logic       we_n,
    output strobe_ev_t ev
);
    logic strb_q;
    logic we_q;

    // Keep the previous sample of each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb_q <= 1'b1;
            we_q   <= 1'b1;
        end else begin
            strb_q <= strb_n;
            we_q   <= we_n;
        end
    end

    // Compare the current sample with the stored one to find edges.
    always_comb begin
        ev.strb_fall = strb_q & ~strb_n;
        ev.strb_rise = ~strb_q & strb_n;
        ev.we_rise   = ~we_q & we_n;
    end
endmodule

// File: rtl/els_cycle_ctrl.sv
// Module: cycle sequencing. It latches the address, tracks the open cycle,
// arms and commits writes, and holds the output word after the cycle.
// Assumes rd_word is the array word at addr_q, presented without delay.
module els_cycle_ctrl
    import els_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    parameter int unsigned DW    = DEF_DW,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_ev_t    ev,
    input  logic          strb_n,
    input  logic          sel_lo,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] rd_word,
    output logic [AW-1:0] addr_q,
    output logic          cyc_act,
    output logic          held_v,
    output logic [DW-1:0] hold_q,
    output logic          wr_commit
);
    logic wr_arm;

    // A write ends on whichever of the two strobes rises first.
    assign wr_commit = wr_arm & (ev.we_rise | ev.strb_rise);

    // Latch the address only when the strobe falls.
    always_ff @(posedge clk) begin
        if (!rst_n)            addr_q <= '0;
        else if (ev.strb_fall) addr_q <= addr;
    end

    // The cycle is open from the strobe's fall until its rise.
    always_ff @(posedge clk) begin
        if (!rst_n)            cyc_act <= 1'b0;
        else if (ev.strb_fall) cyc_act <= 1'b1;
        else if (ev.strb_rise) cyc_act <= 1'b0;
    end

    // Arm a write while strobe, selects and write strobe are all low;
    // disarm when it commits.
    always_ff @(posedge clk) begin
        if (!rst_n)                      wr_arm <= 1'b0;
        else if (wr_commit)              wr_arm <= 1'b0;
        else if (!strb_n && sel_lo && !we_n) wr_arm <= 1'b1;
    end

    // Capture the presented word on the strobe's rise; release it on its fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_v <= 1'b0;
            hold_q <= '0;
        end else if (ev.strb_rise) begin
            held_v <= 1'b1;
            hold_q <= rd_word;
        end else if (ev.strb_fall) begin
            held_v <= 1'b0;
        end
    end

    a_r1_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !ev.strb_fall |=> $stable(addr_q));
    a_r4_hold_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ev.strb_rise |=> (held_v && !cyc_act));
    a_r6_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ev.strb_fall |=> (!held_v && cyc_act));
    a_r10_commit_once: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);
endmodule

// File: rtl/els_bit_array.sv
// Module: the storage array. It has one synchronous write port and one
// asynchronous read port. Contents are not cleared by reset.
// Assumes the write and read addresses are in range (depth is 2**AW).
module els_bit_array
    import els_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    parameter int unsigned DW    = DEF_DW,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wen,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store the write word on a commit.
    always_ff @(posedge clk) begin
        if (wen) mem[waddr] <= wdata;
    end

    // Present the addressed word.
    assign rdata = mem[raddr];
endmodule

// File: rtl/edge_latched_sram.sv
// Module: top of the edge-latched static memory. It joins edge detection,
// cycle control and the array, and forms the output enable and data.
// Assumes all inputs are synchronous to clk. q reads 0 while q_oe is low.
module edge_latched_sram
    import els_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    parameter int unsigned DW    = DEF_DW,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strb_n,
    input  logic          sel_a_n,
    input  logic          sel_b_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q,
    output logic          q_oe
);
    strobe_ev_t    ev;
    logic          sel_lo;
    logic [AW-1:0] addr_q;
    logic          cyc_act;
    logic          held_v;
    logic [DW-1:0] hold_q;
    logic          wr_commit;
    logic [DW-1:0] rd_word;

    assign sel_lo = ~sel_a_n & ~sel_b_n;

    els_strobe_edges u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .strb_n (strb_n),
        .we_n   (we_n),
        .ev     (ev)
    );

    els_cycle_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .strb_n    (strb_n),
        .sel_lo    (sel_lo),
        .we_n      (we_n),
        .addr      (addr),
        .rd_word   (rd_word),
        .addr_q    (addr_q),
        .cyc_act   (cyc_act),
        .held_v    (held_v),
        .hold_q    (hold_q),
        .wr_commit (wr_commit)
    );

    els_bit_array #(.DEPTH(DEPTH), .DW(DW)) u_array (
        .clk   (clk),
        .wen   (wr_commit),
        .waddr (addr_q),
        .wdata (d),
        .raddr (addr_q),
        .rdata (rd_word)
    );

    // Drive while selected and reading, during an open cycle or from the hold.
    always_comb begin
        q_oe = sel_lo & we_n & (cyc_act | held_v);
        if (!q_oe)       q = '0;
        else if (cyc_act) q = rd_word;
        else             q = hold_q;
    end

    a_r8_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        q_oe |-> we_n);
    a_r2_disabled_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !q_oe |-> (q == '0));
endmodule

// File: tb/edge_latched_sram_tb.sv
// Bench: directed scenarios, one task each, every task checking its own results.
module edge_latched_sram_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       strb_n, sel_a_n, sel_b_n, we_n;
    logic [9:0] addr;
    logic [0:0] d;
    logic [0:0] q;
    logic       q_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    edge_latched_sram u_dut (
        .clk(clk), .rst_n(rst_n), .strb_n(strb_n), .sel_a_n(sel_a_n),
        .sel_b_n(sel_b_n), .we_n(we_n), .addr(addr), .d(d), .q(q), .q_oe(q_oe)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic oe_exp, input logic q_exp);
        n_chk++;
        if (q_oe !== oe_exp || q[0] !== q_exp) begin
            n_bad++;
            $display("FAIL %s: oe=%b q=%b expected oe=%b q=%b", req, q_oe, q[0], oe_exp, q_exp);
        end
    endtask

    // Write one bit, ended by the write strobe rising (R7).
    task automatic wr_by_we(input logic [9:0] a, input logic v);
        strb_n = 0; sel_a_n = 0; sel_b_n = 0; we_n = 1; addr = a; tick();
        we_n = 0; addr = ~a; tick();
        chk("R8", 1'b0, 1'b0);
        d = v; we_n = 1; tick();
        d = ~v; strb_n = 1; tick();
    endtask

    // Write one bit, ended by the cycle strobe rising first (R7).
    task automatic wr_by_strb(input logic [9:0] a, input logic v);
        strb_n = 0; sel_a_n = 0; sel_b_n = 0; we_n = 0; addr = a; tick();
        d = v; strb_n = 1; tick();
        d = ~v; we_n = 1; tick();
    endtask

    task automatic t_reset();
        chk("R9", 1'b0, 1'b0);
    endtask

    // Read with an address change after the fall, then hold, deselect, reselect.
    task automatic t_read_hold(input logic [9:0] a, input logic va, input logic [9:0] b, input logic vb);
        strb_n = 0; sel_a_n = 0; sel_b_n = 0; we_n = 1; addr = a; tick();
        chk("R3", 1'b1, va);
        addr = b; tick();
        chk("R1", 1'b1, va);
        strb_n = 1; tick();
        chk("R4", 1'b1, va);
        sel_b_n = 1; tick();
        chk("R2", 1'b0, 1'b0);
        sel_b_n = 0; sel_a_n = 1; tick();
        chk("R2", 1'b0, 1'b0);
        sel_a_n = 0; tick();
        chk("R5", 1'b1, va);
        strb_n = 0; addr = b; tick();
        chk("R6", 1'b1, vb);
        strb_n = 1; tick();
        chk("R4", 1'b1, vb);
    endtask

    // A write with a select high must store nothing.
    task automatic t_desel_write(input logic [9:0] a, input logic old);
        strb_n = 0; sel_a_n = 1; sel_b_n = 0; we_n = 1; addr = a; tick();
        chk("R2", 1'b0, 1'b0);
        we_n = 0; d = ~old; tick();
        we_n = 1; tick();
        strb_n = 1; tick();
        sel_a_n = 0; strb_n = 0; tick();
        chk("R10", 1'b1, old);
        strb_n = 1; tick();
    endtask

    initial begin
        rst_n = 0; strb_n = 1; sel_a_n = 1; sel_b_n = 1; we_n = 1; addr = '0; d = '0;
        tick(); tick();
        rst_n = 1; tick();
        t_reset();
        wr_by_we(10'd5, 1'b1);
        wr_by_we(10'd9, 1'b0);
        wr_by_strb(10'd1023, 1'b1);
        wr_by_strb(10'd0, 1'b0);
        t_read_hold(10'd5, 1'b1, 10'd9, 1'b0);
        t_read_hold(10'd0, 1'b0, 10'd1023, 1'b1);
        t_read_hold(10'd9, 1'b0, 10'd5, 1'b1);
        wr_by_we(10'd5, 1'b0);
        t_read_hold(10'd5, 1'b0, 10'd1023, 1'b1);
        t_desel_write(10'd1023, 1'b1);
        t_desel_write(10'd0, 1'b0);
        sel_a_n = 1; sel_b_n = 1; tick();
        chk("R9", 1'b0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule